// File: doc/BRIEF.md
# Wiper Register Command Controller

This block sits behind a serial-bus slave and turns the instruction bytes it hands over into actions on two 6-bit wiper settings that drive a pair of resistor ladders. Next to each wiper it keeps four 6-bit storage registers that stand in for non-volatile memory. The bus slave tells the block when an addressed frame opens, delivers each received byte with a strobe, and reports the closing condition. It also forwards single-step pulses while the block is in step mode. The block answers read commands with a byte on a read-data port.

Direct writes, transfers and step pulses change the volatile wipers as soon as the relevant byte or pulse arrives. Any change to a storage register is held back until the frame closes. It is then written and followed by a programming interval of a programmable number of clocks, during which the block ignores the bus. After reset the block copies slot 0 of each channel's storage into that channel's wiper.

Top module: `wiper_cmd_ctrl`

## Requirements
- R1: The instruction byte is decoded as opcode = bits 7:4, bit 3 must be 0, channel select = bit 2, storage slot = bits 1:0. The valid opcodes are 0001, 0010, 1000, 1001, 1010, 1011, 1100, 1101 and 1110. A byte with any other opcode, or with bit 3 set, changes no wiper, no storage slot and no read data, and starts no programming interval.
- R2: Opcode 1001 places the selected channel's wiper, zero-extended to 8 bits, on the read-data port in the cycle after the instruction byte strobe.
- R3: Opcode 1010 loads bits 5:0 of the following data byte into the selected wiper in the cycle after that byte's strobe. Bits 7:6 are dropped. No wiper changes unless a byte strobe, a step pulse or the post-reset copy occurred in the previous cycle.
- R4: Opcode 1011 places the selected storage slot of the selected channel, zero-extended, on the read-data port in the cycle after the instruction byte strobe.
- R5: Opcode 1100 stores bits 5:0 of the data byte into the selected slot only when the frame closes. A frame that closes before its data byte leaves the storage unchanged and does not raise busy.
- R6: Opcode 1101 copies the selected slot into the selected channel's wiper in the cycle after the instruction byte strobe. It involves no programming interval.
- R7: Opcode 1110 captures the selected channel's wiper into the selected slot of that channel when the frame closes.
- R8: Opcode 0001 copies slot bits 1:0 of both channels into both wipers at the instruction byte. Opcode 1000 stores both wipers into slot bits 1:0 of their own channels at frame close. Both ignore bit 2.
- R9: After opcode 0010, each step pulse moves the selected wiper one position: up when the direction input is 1 and down when it is 0. The wiper saturates at 0 and 63. Pulses outside this mode have no effect. A pulse in the same cycle as the frame close is still applied.
- R10: A frame close that commits storage raises busy in the next cycle, and busy stays high for exactly PROG_CYCLES cycles. Busy rises at no other time. While busy, frame openings, bytes and step pulses are ignored, so the wipers hold.
- R11: During reset both wipers read 0. At the first clock edge after reset is released, each wiper takes slot 0 of its own channel's storage, and this copy happens only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| frame_start_i | input | 1 | Addressed frame opened (one-cycle pulse) |
| frame_stop_i | input | 1 | Frame closed (one-cycle pulse) |
| byte_stb_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| step_stb_i | input | 1 | Single-step pulse in step mode |
| step_up_i | input | 1 | Step direction, 1 = up |
| rd_data_o | output | 8 | Read-back byte for read commands |
| wiper_o | output | 12 | Wiper settings, channel 0 in bits 5:0, channel 1 in bits 11:6 |
| busy_o | output | 1 | Programming interval in progress |

## Verification
The case to watch is a step pulse that arrives in the same clock cycle as the frame close. Both the step-mode sequencer and the close handling act on that edge. The bench provokes this by driving the step strobe and the close pulse together while one wiper is at 0. It judges the result by requiring the wiper to read 1 afterwards and to stay at 1 when a later, out-of-mode pulse follows. A second overlap is a frame opening attempted while a programming interval runs. The bench requires such a frame to leave the wipers untouched.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

   localparam int unsigned INSTR_W = 8;
   localparam int unsigned SLOT_W  = 2;

   typedef enum logic [3:0] {
      OP_ALL_SLOT2WIP = 4'b0001,
      OP_STEP_MODE    = 4'b0010,
      OP_ALL_WIP2SLOT = 4'b1000,
      OP_RD_WIPER     = 4'b1001,
      OP_WR_WIPER     = 4'b1010,
      OP_RD_SLOT      = 4'b1011,
      OP_WR_SLOT      = 4'b1100,
      OP_SLOT2WIP     = 4'b1101,
      OP_WIP2SLOT     = 4'b1110
   } opcode_e;

   typedef struct packed {
      logic              valid;
      opcode_e           op;
      logic              ch;
      logic [SLOT_W-1:0] slot;
   } instr_t;

   typedef enum logic [2:0] {
      SQ_RECALL,
      SQ_IDLE,
      SQ_INSTR,
      SQ_DATA,
      SQ_STEP,
      SQ_HOLD
   } seq_e;

endpackage

// File: rtl/wcc_instr_decode.sv
module wcc_instr_decode
   import wcc_pkg::*;
(
   input  logic [INSTR_W-1:0] byte_i,
   output instr_t             instr_o
);

   logic known;

   always_comb begin
      case (byte_i[7:4])
         OP_ALL_SLOT2WIP, OP_STEP_MODE, OP_ALL_WIP2SLOT,
         OP_RD_WIPER, OP_WR_WIPER, OP_RD_SLOT,
         OP_WR_SLOT, OP_SLOT2WIP, OP_WIP2SLOT: known = 1'b1;
         default:                              known = 1'b0;
      endcase
   end

   assign instr_o.valid = known & ~byte_i[3];
   assign instr_o.op    = opcode_e'(byte_i[7:4]);
   assign instr_o.ch    = byte_i[2];
   assign instr_o.slot  = byte_i[SLOT_W-1:0];

endmodule

// File: rtl/wcc_nv_store.sv
module wcc_nv_store #(
   parameter int unsigned WIPER_W     = 6,
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned NUM_DR      = 4,
   parameter int unsigned PROG_CYCLES = 1000,
   parameter logic [NUM_CH*NUM_DR*WIPER_W-1:0] DR_INIT = '0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             commit_i,
   input  logic                             commit_all_i,
   input  logic [$clog2(NUM_CH)-1:0]        commit_ch_i,
   input  logic [$clog2(NUM_DR)-1:0]        commit_slot_i,
   input  logic [NUM_CH*WIPER_W-1:0]        commit_data_i,
   output logic [NUM_CH*NUM_DR*WIPER_W-1:0] dr_o,
   output logic                             busy_o
);

   localparam int unsigned CH_W  = $clog2(NUM_CH);
   localparam int unsigned IDX_W = $clog2(NUM_DR);
   localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      for (genvar d = 0; d < NUM_DR; d++) begin : g_slot
         localparam int unsigned POS = (c * NUM_DR + d) * WIPER_W;
         logic [WIPER_W-1:0] q;
         logic               hit;

         assign hit = commit_i && (commit_slot_i == IDX_W'(d)) &&
                      (commit_all_i || (commit_ch_i == CH_W'(c)));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= DR_INIT[POS +: WIPER_W];
            else if (hit) q <= commit_data_i[c*WIPER_W +: WIPER_W];
         end

         assign dr_o[POS +: WIPER_W] = q;
      end
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (commit_i)       cnt_q <= CNT_W'(PROG_CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/wcc_wiper_bank.sv
module wcc_wiper_bank #(
   parameter int unsigned WIPER_W = 6,
   parameter int unsigned NUM_CH  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         ld_i,
   input  logic [NUM_CH*WIPER_W-1:0] ld_val_i,
   input  logic [NUM_CH-1:0]         step_i,
   input  logic                      step_up_i,
   output logic [NUM_CH*WIPER_W-1:0] wiper_o
);

   localparam logic [WIPER_W-1:0] TOP_POS = '1;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_wip
      logic [WIPER_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (ld_i[c]) begin
            q <= ld_val_i[c*WIPER_W +: WIPER_W];
         end else if (step_i[c]) begin
            if (step_up_i && (q != TOP_POS))  q <= q + 1'b1;
            else if (!step_up_i && (q != '0)) q <= q - 1'b1;
         end
      end

      assign wiper_o[c*WIPER_W +: WIPER_W] = q;
   end

endmodule

// File: rtl/wiper_cmd_ctrl.sv
module wiper_cmd_ctrl
   import wcc_pkg::*;
#(
   parameter int unsigned WIPER_W     = 6,
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned NUM_DR      = 4,
   parameter int unsigned PROG_CYCLES = 1000,
   parameter logic [NUM_CH*NUM_DR*WIPER_W-1:0] DR_INIT =
      {6'd7, 6'd6, 6'd5, 6'd45, 6'd3, 6'd2, 6'd1, 6'd20}
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_start_i,
   input  logic                      frame_stop_i,
   input  logic                      byte_stb_i,
   input  logic [7:0]                byte_i,
   input  logic                      step_stb_i,
   input  logic                      step_up_i,
   output logic [7:0]                rd_data_o,
   output logic [NUM_CH*WIPER_W-1:0] wiper_o,
   output logic                      busy_o
);

   localparam int unsigned BANK_W = NUM_CH * WIPER_W;
   localparam int unsigned STORE_W = NUM_CH * NUM_DR * WIPER_W;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("channel select is a single instruction bit: NUM_CH must be 2");
   end
   if (NUM_DR != (1 << SLOT_W)) begin : g_bad_dr
      $error("slot select is two instruction bits: NUM_DR must be 4");
   end
   if (WIPER_W > 8 || WIPER_W < 1) begin : g_bad_w
      $error("wiper width must fit the 8-bit data byte");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("programming interval must last at least one cycle");
   end

   // ---- decode ----
   instr_t dec;
   wcc_instr_decode u_dec (.byte_i(byte_i), .instr_o(dec));

   // ---- sequencer state ----
   seq_e              seq_q, seq_d;
   opcode_e           held_op_q, held_op_d;
   logic              held_ch_q, held_ch_d;
   logic [SLOT_W-1:0] held_slot_q, held_slot_d;
   logic              pend_q, pend_d;
   logic              pend_all_q, pend_all_d;
   logic              pend_ch_q, pend_ch_d;
   logic [SLOT_W-1:0] pend_slot_q, pend_slot_d;
   logic [BANK_W-1:0] pend_data_q, pend_data_d;
   logic [7:0]        rd_q, rd_d;

   logic [NUM_CH-1:0] ld, step;
   logic [BANK_W-1:0] ld_val;
   logic [STORE_W-1:0] dr_flat;
   logic              commit;
   logic              recall_w;

   assign recall_w = (seq_q == SQ_RECALL);

   function automatic logic [WIPER_W-1:0] slot_val(
      input logic [STORE_W-1:0] flat, input logic ch, input logic [SLOT_W-1:0] s);
      return flat[(int'(ch) * NUM_DR + int'(s)) * WIPER_W +: WIPER_W];
   endfunction

   always_comb begin
      seq_d       = seq_q;
      held_op_d   = held_op_q;
      held_ch_d   = held_ch_q;
      held_slot_d = held_slot_q;
      pend_d      = pend_q;
      pend_all_d  = pend_all_q;
      pend_ch_d   = pend_ch_q;
      pend_slot_d = pend_slot_q;
      pend_data_d = pend_data_q;
      rd_d        = rd_q;
      ld          = '0;
      ld_val      = '0;
      step        = '0;
      commit      = 1'b0;

      case (seq_q)
         SQ_RECALL: begin
            for (int c = 0; c < NUM_CH; c++) begin
               ld[c] = 1'b1;
               ld_val[c*WIPER_W +: WIPER_W] = dr_flat[c*NUM_DR*WIPER_W +: WIPER_W];
            end
            seq_d = SQ_IDLE;
         end
         SQ_INSTR: if (byte_stb_i) begin
            held_op_d   = dec.op;
            held_ch_d   = dec.ch;
            held_slot_d = dec.slot;
            seq_d       = SQ_HOLD;
            if (dec.valid) begin
               case (dec.op)
                  OP_RD_WIPER:
                     rd_d = 8'(wiper_o[int'(dec.ch)*WIPER_W +: WIPER_W]);
                  OP_RD_SLOT:
                     rd_d = 8'(slot_val(dr_flat, dec.ch, dec.slot));
                  OP_WR_WIPER, OP_WR_SLOT:
                     seq_d = SQ_DATA;
                  OP_STEP_MODE:
                     seq_d = SQ_STEP;
                  OP_SLOT2WIP: begin
                     ld[dec.ch] = 1'b1;
                     ld_val[int'(dec.ch)*WIPER_W +: WIPER_W] =
                        slot_val(dr_flat, dec.ch, dec.slot);
                  end
                  OP_ALL_SLOT2WIP:
                     for (int c = 0; c < NUM_CH; c++) begin
                        ld[c] = 1'b1;
                        ld_val[c*WIPER_W +: WIPER_W] = slot_val(dr_flat, c[0], dec.slot);
                     end
                  OP_WIP2SLOT: begin
                     pend_d      = 1'b1;
                     pend_all_d  = 1'b0;
                     pend_ch_d   = dec.ch;
                     pend_slot_d = dec.slot;
                     pend_data_d[int'(dec.ch)*WIPER_W +: WIPER_W] =
                        wiper_o[int'(dec.ch)*WIPER_W +: WIPER_W];
                  end
                  OP_ALL_WIP2SLOT: begin
                     pend_d      = 1'b1;
                     pend_all_d  = 1'b1;
                     pend_slot_d = dec.slot;
                     pend_data_d = wiper_o;
                  end
                  default: ;
               endcase
            end
         end
         SQ_DATA: if (byte_stb_i) begin
            seq_d = SQ_HOLD;
            if (held_op_q == OP_WR_WIPER) begin
               ld[held_ch_q] = 1'b1;
               ld_val[int'(held_ch_q)*WIPER_W +: WIPER_W] = byte_i[WIPER_W-1:0];
            end else begin
               pend_d      = 1'b1;
               pend_all_d  = 1'b0;
               pend_ch_d   = held_ch_q;
               pend_slot_d = held_slot_q;
               pend_data_d[int'(held_ch_q)*WIPER_W +: WIPER_W] = byte_i[WIPER_W-1:0];
            end
         end
         SQ_STEP: if (step_stb_i) begin
            step[held_ch_q] = 1'b1;
         end
         default: ;
      endcase

      if (seq_q != SQ_RECALL) begin
         if (frame_stop_i) begin
            commit = pend_q;
            pend_d = 1'b0;
            seq_d  = SQ_IDLE;
         end
         if (frame_start_i && !busy_o && !commit) begin
            pend_d = 1'b0;
            seq_d  = SQ_INSTR;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q       <= SQ_RECALL;
         held_op_q   <= OP_RD_WIPER;
         held_ch_q   <= 1'b0;
         held_slot_q <= '0;
         pend_q      <= 1'b0;
         pend_all_q  <= 1'b0;
         pend_ch_q   <= 1'b0;
         pend_slot_q <= '0;
         pend_data_q <= '0;
         rd_q        <= '0;
      end else begin
         seq_q       <= seq_d;
         held_op_q   <= held_op_d;
         held_ch_q   <= held_ch_d;
         held_slot_q <= held_slot_d;
         pend_q      <= pend_d;
         pend_all_q  <= pend_all_d;
         pend_ch_q   <= pend_ch_d;
         pend_slot_q <= pend_slot_d;
         pend_data_q <= pend_data_d;
         rd_q        <= rd_d;
      end
   end

   wcc_nv_store #(
      .WIPER_W(WIPER_W), .NUM_CH(NUM_CH), .NUM_DR(NUM_DR),
      .PROG_CYCLES(PROG_CYCLES), .DR_INIT(DR_INIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .commit_i(commit), .commit_all_i(pend_all_q),
      .commit_ch_i(pend_ch_q), .commit_slot_i(pend_slot_q),
      .commit_data_i(pend_data_q),
      .dr_o(dr_flat), .busy_o(busy_o)
   );

   wcc_wiper_bank #(.WIPER_W(WIPER_W), .NUM_CH(NUM_CH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .ld_i(ld), .ld_val_i(ld_val),
      .step_i(step), .step_up_i(step_up_i),
      .wiper_o(wiper_o)
   );

   assign rd_data_o = rd_q;

endmodule

// File: rtl/wiper_cmd_ctrl_chk.sv
module wiper_cmd_ctrl_chk #(
   parameter int unsigned WIPER_W = 6,
   parameter int unsigned NUM_CH  = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      byte_stb_i,
   input logic                      step_stb_i,
   input logic                      frame_stop_i,
   input logic [NUM_CH*WIPER_W-1:0] wiper_o,
   input logic                      busy_o,
   input logic                      recall_i
);

   logic [NUM_CH*WIPER_W-1:0] prev_w;
   logic [NUM_CH-1:0]         unit_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_w <= '0;
      else        prev_w <= wiper_o;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_unit
      logic [WIPER_W-1:0] cur, old;
      assign cur = wiper_o[c*WIPER_W +: WIPER_W];
      assign old = prev_w[c*WIPER_W +: WIPER_W];
      assign unit_ok[c] = (cur == old) || (cur == old + 1'b1) || (cur + 1'b1 == old);
   end

   a_r10_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(frame_stop_i));

   a_r10_busy_holds_wipers: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(wiper_o));

   a_r3_quiet_wipers: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(byte_stb_i) && !$past(step_stb_i) && !$past(recall_i)) |-> $stable(wiper_o));

   a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(step_stb_i) && !$past(byte_stb_i) && !$past(recall_i)) |-> (&unit_ok));

   a_r11_recall_once: assert property (@(posedge clk) disable iff (!rst_n)
      recall_i |=> !recall_i);

endmodule

bind wiper_cmd_ctrl wiper_cmd_ctrl_chk #(.WIPER_W(WIPER_W), .NUM_CH(NUM_CH)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .byte_stb_i(byte_stb_i), .step_stb_i(step_stb_i), .frame_stop_i(frame_stop_i),
   .wiper_o(wiper_o), .busy_o(busy_o), .recall_i(recall_w)
);

// File: tb/wiper_cmd_ctrl_tb_top.sv
module wiper_cmd_ctrl_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned PROG = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0, frame_stop = 1'b0, byte_stb = 1'b0;
   logic [7:0]  byte_d = '0;
   logic        step_stb = 1'b0, step_up = 1'b0;
   logic [7:0]  rd_data;
   logic [11:0] wiper;
   logic        busy;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   wiper_cmd_ctrl #(.PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .frame_start_i(frame_start), .frame_stop_i(frame_stop),
      .byte_stb_i(byte_stb), .byte_i(byte_d),
      .step_stb_i(step_stb), .step_up_i(step_up),
      .rd_data_o(rd_data), .wiper_o(wiper), .busy_o(busy)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int w0(); return int'(wiper[5:0]);  endfunction
   function automatic int w1(); return int'(wiper[11:6]); endfunction

   task automatic open_frame();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
   endtask

   task automatic close_frame();
      @(negedge clk); frame_stop = 1'b1;
      @(negedge clk); frame_stop = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); byte_d = b; byte_stb = 1'b1;
      @(negedge clk); byte_stb = 1'b0;
   endtask

   task automatic pulse_step(input logic up, input logic with_stop);
      @(negedge clk); step_stb = 1'b1; step_up = up; frame_stop = with_stop;
      @(negedge clk); step_stb = 1'b0; frame_stop = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic set_wiper(input int ch, input int v);
      open_frame(); send(8'hA0 | 8'(ch << 2)); send(8'(v)); close_frame();
   endtask

   task automatic read_slot(input int ch, input int s, output int v);
      open_frame(); send(8'hB0 | 8'(ch << 2) | 8'(s)); v = int'(rd_data); close_frame();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 wiper0 in reset", w0(), 0);
      check("R11 wiper1 in reset", w1(), 0);
      check("R10 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 recall wiper0", w0(), 20);
      check("R11 recall wiper1", w1(), 45);
   endtask

   task automatic t_read_wiper();
      open_frame(); send(8'h90);
      check("R2 read wiper0", int'(rd_data), 20);
      close_frame();
      open_frame(); send(8'h94);
      check("R2 read wiper1", int'(rd_data), 45);
      close_frame();
   endtask

   task automatic t_write_wiper();
      set_wiper(1, 8'hFF);
      check("R3 write wiper1 drops bits 7:6", w1(), 63);
      check("R3 wiper0 untouched", w0(), 20);
      check("R10 no busy for wiper write", int'(busy), 0);
   endtask

   task automatic t_read_slot();
      int v;
      read_slot(1, 2, v);
      check("R4 read ch1 slot2", v, 6);
   endtask

   task automatic t_write_slot();
      int v, len;
      read_slot(0, 1, v);
      check("R5 slot before write", v, 1);
      open_frame(); send(8'hC1); send(8'hEA);
      check("R5 no busy before close", int'(busy), 0);
      close_frame();
      len = 0;
      while (busy && len < 1000) begin len++; @(negedge clk); end
      check("R10 busy length", len, PROG);
      read_slot(0, 1, v);
      check("R5 slot after close", v, 42);
   endtask

   task automatic t_abort();
      int v;
      open_frame(); send(8'hC2); close_frame();
      check("R5 short frame no busy", int'(busy), 0);
      repeat (3) @(negedge clk);
      check("R5 short frame still no busy", int'(busy), 0);
      read_slot(0, 2, v);
      check("R5 short frame slot kept", v, 2);
   endtask

   task automatic t_invalid();
      open_frame(); send(8'h90); close_frame();
      open_frame(); send(8'h30); send(8'h11); close_frame();
      open_frame(); send(8'hF4); send(8'h22); close_frame();
      check("R1 bad opcode wiper0", w0(), 20);
      check("R1 bad opcode wiper1", w1(), 63);
      check("R1 bad opcode no busy", int'(busy), 0);
      open_frame(); send(8'h9C);
      check("R1 bit3 set gives no read", int'(rd_data), 20);
      close_frame();
      open_frame(); send(8'hA8); send(8'h05); close_frame();
      check("R1 bit3 set gives no write", w0(), 20);
   endtask

   task automatic t_slot2wip();
      open_frame(); send(8'hD7);
      check("R6 slot to wiper1", w1(), 7);
      check("R6 wiper0 untouched", w0(), 20);
      close_frame();
      check("R6 no busy", int'(busy), 0);
   endtask

   task automatic t_wip2slot();
      int v;
      open_frame(); send(8'hE3); close_frame();
      check("R7 busy after capture", int'(busy), 1);
      open_frame(); send(8'hA0); send(8'h05); close_frame();
      check("R10 write ignored while busy", w0(), 20);
      wait_idle();
      read_slot(0, 3, v);
      check("R7 captured into slot", v, 20);
   endtask

   task automatic t_global();
      int v;
      set_wiper(0, 11);
      set_wiper(1, 22);
      open_frame(); send(8'h82); close_frame();
      check("R8 global store busy", int'(busy), 1);
      wait_idle();
      read_slot(0, 2, v);
      check("R8 global store ch0", v, 11);
      read_slot(1, 2, v);
      check("R8 global store ch1", v, 22);
      set_wiper(0, 33);
      set_wiper(1, 44);
      open_frame(); send(8'h16);
      check("R8 global load wiper0", w0(), 11);
      check("R8 global load wiper1", w1(), 22);
      close_frame();
   endtask

   task automatic t_step();
      set_wiper(0, 62);
      open_frame(); send(8'h20);
      pulse_step(1'b1, 1'b0);
      check("R9 step up", w0(), 63);
      pulse_step(1'b1, 1'b0);
      check("R9 saturate at 63", w0(), 63);
      pulse_step(1'b0, 1'b0);
      pulse_step(1'b0, 1'b0);
      check("R9 step down twice", w0(), 61);
      check("R9 other wiper untouched", w1(), 22);
      close_frame();
      pulse_step(1'b1, 1'b0);
      check("R9 step outside mode ignored", w0(), 61);
      set_wiper(1, 0);
      open_frame(); send(8'h24);
      pulse_step(1'b0, 1'b0);
      check("R9 saturate at 0", w1(), 0);
      pulse_step(1'b1, 1'b1);
      check("R9 step with close applied", w1(), 1);
      check("R9 step with close no busy", int'(busy), 0);
      pulse_step(1'b1, 1'b0);
      check("R9 step after close ignored", w1(), 1);
   endtask

   initial begin
      t_reset();
      t_read_wiper();
      t_write_wiper();
      t_read_slot();
      t_write_slot();
      t_abort();
      t_invalid();
      t_slot2wip();
      t_wip2slot();
      t_global();
      t_step();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule